// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver with Inactivity Timeout

This block takes the open-drain clock and data wires of a PS/2 keyboard and recovers the scan-code bytes the device sends to the host. Both wires are brought into the system clock domain through two-flop synchronizers. The data wire is sampled on each falling edge of the synchronized keyboard clock, and an 11-bit frame is walked through: a start bit, eight data bits, an odd-parity bit and a stop bit.

A byte that passes all checks is presented for one cycle on a valid strobe, ready to be written into a small circular scan-code buffer outside the block. A parity failure abandons the frame and pulses a request asking the host transmitter to send the resend command (0xFE) to the keyboard. A frame that stalls, with no falling clock edge for a fixed time (100 µs by default), is dropped, so the next frame starts clean. While another agent (the host transmitter or a shift-out path) owns the shared wires, reception is suppressed.

Top module: `ps2_kbd_rx`

## Requirements
- R1: Each accepted frame delivers the eight data bits in the order received, the first data bit after the start bit landing in bit 0 of `rx_byte_o`.
- R2: While no frame is in progress, a falling edge with the data wire high is ignored and the receiver keeps waiting for a low start bit.
- R3: Parity is odd: a frame is accepted only if the parity bit is 1 when the data byte holds an even number of ones and 0 when it holds an odd number.
- R4: On a parity mismatch, `resend_req_o` pulses high for exactly one cycle, no byte is delivered, and the receiver is ready for a new start bit.
- R5: The stop bit must be high. A high stop bit after good parity pulses `rx_valid_o` for one cycle with the byte on `rx_byte_o`. A low stop bit discards the byte. Either way the receiver waits for a new start bit.
- R6: If no falling edge arrives for TIMEOUT_US microseconds of system clock (CLK_HZ/1e6 cycles per microsecond), a frame in progress is abandoned.
- R7: Every accepted falling edge restarts the inactivity timer, so a pause shorter than the timeout within a frame does not disturb reception.
- R8: While `line_busy_i` is high, keyboard clock edges are ignored and any partial frame is abandoned.
- R9: During and right after reset, `rx_valid_o`, `resend_req_o` and `rx_byte_o` are all zero.
- R10: `rx_valid_o` and `resend_req_o` are never high in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_clk_i | input | 1 | PS/2 clock wire as read from the pad (asynchronous) |
| kbd_dat_i | input | 1 | PS/2 data wire as read from the pad (asynchronous) |
| line_busy_i | input | 1 | High while another agent drives the shared wires |
| rx_valid_o | output | 1 | One-cycle strobe: a good byte is on rx_byte_o |
| rx_byte_o | output | 8 | Last good byte received |
| resend_req_o | output | 1 | One-cycle request to send the resend command 0xFE |

## Verification
The hardest situation to reach from the ports is a stalled frame. The receiver has to be left part-way through its bits and then starved of clock edges for longer than the timeout. The bench sends a start bit and a few data bits, goes silent for more than 100 µs of system clock, and then sends a complete frame. Only a receiver that abandoned the stalled frame delivers that byte unchanged. A second frame pauses for well under the timeout in the middle of its data bits, which shows that each edge restarts the timer and that the timeout does not fire early.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_PAR  = 2'd2,
    ST_STOP = 2'd3
  } rx_state_e;

  localparam int unsigned BYTE_W   = 8;
  localparam logic [7:0]  RESEND_CMD = 8'hFE;
endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= {W{RST_VAL}};
        else        stg_q[s] <= async_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= {W{RST_VAL}};
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/ps2rx_timer.sv
module ps2rx_timer #(
  parameter int unsigned TICK_DIV = 200,
  parameter int unsigned LIMIT    = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic expired_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned UW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [UW-1:0] US_LAST  = UW'(LIMIT - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [UW-1:0] us_q, us_d;
  logic          exp_q, exp_d;

  always_comb begin
    pre_d = pre_q;
    us_d  = us_q;
    exp_d = exp_q;
    if (restart_i) begin
      pre_d = '0;
      us_d  = '0;
      exp_d = 1'b0;
    end else if (!exp_q) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        if (us_q == US_LAST) begin
          us_d  = '0;
          exp_d = 1'b1;
        end else begin
          us_d = us_q + 1'b1;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
      exp_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      us_q  <= us_d;
      exp_q <= exp_d;
    end
  end

  assign expired_o = exp_q;

  // R7: a restart always clears the expiry in the next cycle
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !expired_o);
  // R6: once expired, the flag stays until a restart
  a_r6_expiry_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !restart_i) |=> expired_o);
endmodule

// File: rtl/ps2rx_fsm.sv
module ps2rx_fsm
  import ps2rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              dat_i,
  input  logic              abort_i,
  input  logic              tmo_i,
  output logic              accept_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              resend_o
);
  localparam int unsigned CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);

  rx_state_e         st_q, st_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              vld_q, vld_d;
  logic              rs_q, rs_d;
  logic              edge_ok;
  logic              par_exp;

  assign edge_ok = fall_i && !abort_i;
  assign par_exp = ~^sh_q;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    rs_d   = 1'b0;
    if (abort_i) begin
      st_d = ST_IDLE;
    end else if (fall_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (!dat_i) begin
            st_d  = ST_DATA;
            cnt_d = '0;
            sh_d  = '0;
          end
        end
        ST_DATA: begin
          sh_d  = {dat_i, sh_q[BYTE_W-1:1]};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) st_d = ST_PAR;
        end
        ST_PAR: begin
          if (dat_i == par_exp) begin
            st_d = ST_STOP;
          end else begin
            st_d = ST_IDLE;
            rs_d = 1'b1;
          end
        end
        ST_STOP: begin
          st_d = ST_IDLE;
          if (dat_i) begin
            vld_d  = 1'b1;
            byte_d = sh_q;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end else if (tmo_i) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
      rs_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
      rs_q   <= rs_d;
    end
  end

  assign accept_o   = edge_ok;
  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;
  assign resend_o   = rs_q;

  // R10: the two result strobes are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld_o && resend_o));
  // R10: a byte strobe lasts a single cycle
  a_r10_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);
  // R4: after a resend request the receiver waits for a new start bit
  a_r4_resend_idle: assert property (@(posedge clk) disable iff (!rst_n)
    resend_o |-> (st_q == ST_IDLE));
  // R5: a delivered byte leaves the receiver waiting for a new start bit
  a_r5_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> (st_q == ST_IDLE));
  // R8: line ownership by another agent abandons the frame
  a_r8_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (st_q == ST_IDLE));
  // R6: an expired timer with no edge drops the frame
  a_r6_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_i && !fall_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/ps2_kbd_rx.sv
module ps2_kbd_rx #(
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned TIMEOUT_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_clk_i,
  input  logic       kbd_dat_i,
  input  logic       line_busy_i,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       resend_req_o
);
  localparam int unsigned TICK_DIV = CLK_HZ / 1_000_000;

  logic [1:0] pins_s;
  logic       kclk_s, kdat_s, kclk_q, fall, accept, tmo;

  ps2rx_sync #(.W(2), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({kbd_clk_i, kbd_dat_i}),
    .sync_o  (pins_s)
  );

  assign kclk_s = pins_s[1];
  assign kdat_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kclk_q <= 1'b1;
    else        kclk_q <= kclk_s;
  end

  assign fall = kclk_q && !kclk_s;

  ps2rx_timer #(.TICK_DIV(TICK_DIV), .LIMIT(TIMEOUT_US)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (accept),
    .expired_o (tmo)
  );

  ps2rx_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_i     (fall),
    .dat_i      (kdat_s),
    .abort_i    (line_busy_i),
    .tmo_i      (tmo),
    .accept_o   (accept),
    .byte_vld_o (rx_valid_o),
    .byte_o     (rx_byte_o),
    .resend_o   (resend_req_o)
  );

  // R9: no result strobe in the first cycle after reset release
  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rx_valid_o && !resend_req_o));
endmodule

// File: tb/test_ps2_kbd_rx.sv
module test_ps2_kbd_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_clk = 1'b1;
  logic       kbd_dat = 1'b1;
  logic       busy = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       resend_req;

  localparam int HALF = 20;

  typedef struct {
    logic       is_rs;
    logic [7:0] data;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;

  ps2_kbd_rx i_ps2_kbd_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .kbd_clk_i    (kbd_clk),
    .kbd_dat_i    (kbd_dat),
    .line_busy_i  (busy),
    .rx_valid_o   (rx_valid),
    .rx_byte_o    (rx_byte),
    .resend_req_o (resend_req)
  );

  function automatic void summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endfunction

  // monitor: pop and compare on every result strobe
  always @(negedge clk) begin
    if (rst_n && (rx_valid || resend_req)) begin
      exp_t e;
      checks++;
      if (rx_valid && resend_req) begin
        fails++;
        $display("FAIL R10: both strobes high, got vld=1 rs=1 expected one");
      end else if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected result: got rs=%0b byte=%02h expected none",
                 resend_req, rx_byte);
      end else begin
        e = exp_q.pop_front();
        if (resend_req != e.is_rs || (!e.is_rs && rx_byte != e.data)) begin
          fails++;
          $display("FAIL %s: got rs=%0b byte=%02h expected rs=%0b byte=%02h",
                   e.req, resend_req, rx_byte, e.is_rs, e.data);
        end
      end
    end
  end

  // R10: a strobe never lasts two cycles
  logic prev_v = 1'b0, prev_r = 1'b0;
  always @(negedge clk) begin
    if (rst_n && ((prev_v && rx_valid) || (prev_r && resend_req))) begin
      checks++;
      fails++;
      $display("FAIL R10: strobe held two cycles, got 1 expected 0");
    end
    prev_v <= rx_valid;
    prev_r <= resend_req;
  end

  task automatic bit_out(input logic b);
    @(negedge clk);
    kbd_dat = b;
    repeat (HALF) @(negedge clk);
    kbd_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    kbd_clk = 1'b1;
  endtask

  task automatic expect_item(input logic rs, input logic [7:0] d, input string req);
    exp_t e;
    e.is_rs = rs;
    e.data  = d;
    e.req   = req;
    exp_q.push_back(e);
  endtask

  // send a full frame; gap_at >= 0 inserts a pause after that many data bits
  task automatic frame(input logic [7:0] d, input logic par_ok, input logic stop_b,
                       input int gap_at, input int gap_cyc);
    logic p;
    p = ~^d;
    if (!par_ok) p = ~p;
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) begin
      if (i == gap_at) repeat (gap_cyc) @(negedge clk);
      bit_out(d[i]);
    end
    bit_out(p);
    bit_out(stop_b);
    repeat (10) @(negedge clk);
    kbd_dat = 1'b1;
  endtask

  task automatic good(input logic [7:0] d, input string req);
    expect_item(1'b0, d, req);
    frame(d, 1'b1, 1'b1, -1, 0);
  endtask

  task automatic check(input bit ok, input string req, input int got, input int want);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, want);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R9: reset state
    check(rx_valid == 1'b0, "R9", int'(rx_valid), 0);
    check(resend_req == 1'b0, "R9", int'(resend_req), 0);
    check(rx_byte == 8'h00, "R9", int'(rx_byte), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 R3 R5: plain frames, mixed parity weights
    good(8'h1C, "R1");
    good(8'hF0, "R3");
    good(8'h00, "R3");
    good(8'hFF, "R3");
    good(8'h81, "R5");

    // R4: parity error, then a good frame right after
    expect_item(1'b1, 8'hFE, "R4");
    frame(8'h33, 1'b0, 1'b1, -1, 0);
    good(8'h44, "R4");

    // R5: low stop bit discards, then a good frame
    frame(8'h55, 1'b1, 1'b0, -1, 0);
    good(8'h66, "R5");

    // R2: high samples while waiting for a start bit are ignored
    bit_out(1'b1);
    bit_out(1'b1);
    bit_out(1'b1);
    good(8'h77, "R2");

    // R6: stalled partial frame, silence longer than the timeout
    bit_out(1'b0);
    bit_out(1'b1);
    bit_out(1'b0);
    bit_out(1'b1);
    repeat (21000) @(negedge clk);
    good(8'h29, "R6");

    // R7: pause shorter than the timeout in mid frame
    expect_item(1'b0, 8'hA5, "R7");
    frame(8'hA5, 1'b1, 1'b1, 4, 15000);

    // R8: busy mid frame, remaining bits ignored
    bit_out(1'b0);
    bit_out(1'b1);
    bit_out(1'b1);
    bit_out(1'b0);
    bit_out(1'b0);
    busy = 1'b1;
    for (int i = 0; i < 6; i++) bit_out(1'b1);
    busy = 1'b0;
    repeat (10) @(negedge clk);
    good(8'h3C, "R8");

    repeat (50) @(negedge clk);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end
endmodule